// File: doc/BRIEF.md
# Load-Store Dependence Predictor

This block decides, cycle by cycle, whether a load that has its address may go to memory while older stores in the window still have unknown addresses. It keeps a small table of in-flight stores, each tagged with a sequence number and a flag that records whether its address is known yet. It also keeps a small table of loads that went ahead of unresolved older stores. When one of those stores later resolves to the same word as a tracked younger load, the block raises a one-cycle replay pulse that carries the program counter of the offending load. The load pipeline does the real cache access, forwarding and squash. This block only grants or stalls, and flags the hazard.

Three disambiguation policies can be selected at run time. The conservative policy holds a load until every older store is resolved. The aggressive policy lets it go at once. The predicted policy reads a one-bit wait table indexed by the load PC. A load is optimistic until it has caused a replay, and after that it waits like the conservative policy. The whole wait table is wiped at regular intervals so that stale predictions decay.

Top module: `ld_dep_predictor`

## Requirements
- R1: With `policy_i` = 0 (conservative), a requesting load is granted exactly when no valid store older than it has an unknown address. A store whose address is being resolved in the same cycle counts as known.
- R2: With `policy_i` = 1 (aggressive), a load is granted past older unresolved stores when a tracking slot is free, and is stalled when all LQ_DEPTH slots are in use. A slot is freed once no older unresolved store remains for its load.
- R3: With `policy_i` = 2 or 3 (predicted), a load behaves as in R2 when its wait bit is clear and as in R1 when it is set.
- R4: When a store resolves to an address in the same word as a tracked load that is younger than the store, `viol_o` is high for the one cycle after the resolve, and `viol_pc_o` gives that load's PC. If several tracked loads match, the oldest of them is reported.
- R5: Addresses are compared with bits [1:0] ignored, so a differing byte offset inside one word still matches. Loads older than the resolving store, and loads in a different word, raise no pulse.
- R6: A replay sets the wait bit at index PC[WT_IDX_W+1:2] of the offending load. Every load PC with the same index bits shares that bit.
- R7: Reset clears the whole wait table, and so does the end of every DECAY_CYCLES-cycle interval after reset. A replay in the same cycle as a wipe still sets its bit.
- R8: Sequence numbers are SEQ_W bits wide and wrap. Store a is older than load b when bit SEQ_W-1 of (a - b) is 1. Stores that are not older than the load never stall it.
- R9: A flush removes every store and every tracked load whose sequence number is strictly younger than `flush_seq_i`. A retire removes the store with the matching sequence number.
- R10: Out of reset `viol_o` is low, and neither grant nor stall is driven while `ld_req_i` is low.
- R11: While `ld_req_i` is high, exactly one of `ld_grant_o` and `ld_stall_o` is high, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 2 | 0 conservative, 1 aggressive, 2/3 predicted |
| st_alloc_i | input | 1 | Allocate a store entry |
| st_alloc_seq_i | input | SEQ_W | Sequence number of the allocated store |
| st_res_i | input | 1 | A store address becomes known |
| st_res_seq_i | input | SEQ_W | Sequence number of the resolving store |
| st_res_addr_i | input | ADDR_W | Address of the resolving store |
| st_ret_i | input | 1 | Retire a store |
| st_ret_seq_i | input | SEQ_W | Sequence number of the retiring store |
| ld_req_i | input | 1 | Load asks to issue |
| ld_pc_i | input | PC_W | PC of the requesting load |
| ld_addr_i | input | ADDR_W | Address of the requesting load |
| ld_seq_i | input | SEQ_W | Sequence number of the requesting load |
| flush_i | input | 1 | Flush younger work |
| flush_seq_i | input | SEQ_W | Entries younger than this are dropped |
| ld_grant_o | output | 1 | Load may issue this cycle |
| ld_stall_o | output | 1 | Load must wait |
| viol_o | output | 1 | Replay pulse |
| viol_pc_o | output | PC_W | PC of the load to replay |

## Verification
The hardest case to reach is a replay that has to choose between several tracked loads in the same word. The bench first trains one load so that the wait table holds state. It then issues two aggressive loads to one word in reverse age order, so the younger load takes the lower slot, and resolves their shared older store. A wrong choice would report the younger PC. Wrap-around age is reached by allocating a store with a sequence number near the top of the range against a load just past zero. Decay is reached with a short DECAY_CYCLES, and the bench checks that a trained load stalls before the wipe and is granted after it.

// File: rtl/ld_dep_pkg.sv
package ld_dep_pkg;

    typedef enum logic [1:0] {
        POL_CONSERVATIVE = 2'd0,
        POL_AGGRESSIVE   = 2'd1,
        POL_PREDICTED    = 2'd2,
        POL_PREDICTED_B  = 2'd3
    } dep_policy_e;

    // Wrap-aware age: a is older than b when (a - b) is negative in w bits.
    function automatic logic seq_is_older(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input int unsigned w);
        logic [31:0] diff;
        diff = a - b;
        return diff[w-1];
    endfunction

    // Word-granular address match: byte offset bits ignored.
    function automatic logic same_word(input logic [63:0] a,
                                       input logic [63:0] b);
        return a[63:2] == b[63:2];
    endfunction

endpackage

// File: rtl/ld_dep_store_table.sv
module ld_dep_store_table
    import ld_dep_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          alloc_i,
    input  logic [SEQ_W-1:0]              alloc_seq_i,
    input  logic                          res_i,
    input  logic [SEQ_W-1:0]              res_seq_i,
    input  logic                          ret_i,
    input  logic [SEQ_W-1:0]              ret_seq_i,
    input  logic                          flush_i,
    input  logic [SEQ_W-1:0]              flush_seq_i,
    output logic [DEPTH-1:0]              valid_o,
    output logic [DEPTH-1:0]              pending_o,
    output logic [DEPTH-1:0][SEQ_W-1:0]   seq_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic             valid;
        logic             known;
        logic [SEQ_W-1:0] seq;
    } st_entry_t;

    st_entry_t ent_q [DEPTH];
    st_entry_t ent_d [DEPTH];

    logic             slot_ok;
    logic [IDX_W-1:0] slot_idx;

    always_comb begin
        slot_ok  = 1'b0;
        slot_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!ent_q[i].valid && !slot_ok) begin
                slot_ok  = 1'b1;
                slot_idx = IDX_W'(i);
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic res_hit, ret_hit, flushed;
        assign res_hit = res_i && (res_seq_i == ent_q[g].seq);
        assign ret_hit = ret_i && (ret_seq_i == ent_q[g].seq);
        assign flushed = flush_i &&
                         seq_is_older(32'(flush_seq_i), 32'(ent_q[g].seq), SEQ_W);

        assign valid_o[g]   = ent_q[g].valid;
        assign seq_o[g]     = ent_q[g].seq;
        assign pending_o[g] = ent_q[g].valid && !ent_q[g].known && !res_hit && !ret_hit;

        always_comb begin
            ent_d[g] = ent_q[g];
            if (ent_q[g].valid) begin
                if (flushed || ret_hit) begin
                    ent_d[g].valid = 1'b0;
                end else if (res_hit) begin
                    ent_d[g].known = 1'b1;
                end
            end
            if (alloc_i && !flush_i && slot_ok && (slot_idx == IDX_W'(g))) begin
                ent_d[g].valid = 1'b1;
                ent_d[g].known = 1'b0;
                ent_d[g].seq   = alloc_seq_i;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
            end
        end
    end

endmodule

// File: rtl/ld_dep_spec_loads.sv
module ld_dep_spec_loads
    import ld_dep_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int SQ_DEPTH = 8,
    parameter int SEQ_W    = 6,
    parameter int ADDR_W   = 32,
    parameter int PC_W     = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           add_i,
    input  logic [SEQ_W-1:0]               add_seq_i,
    input  logic [ADDR_W-1:0]              add_addr_i,
    input  logic [PC_W-1:0]                add_pc_i,
    input  logic [SQ_DEPTH-1:0]            st_pending_i,
    input  logic [SQ_DEPTH-1:0][SEQ_W-1:0] st_seq_i,
    input  logic                           res_i,
    input  logic [SEQ_W-1:0]               res_seq_i,
    input  logic [ADDR_W-1:0]              res_addr_i,
    input  logic                           flush_i,
    input  logic [SEQ_W-1:0]               flush_seq_i,
    output logic                           free_o,
    output logic                           hit_o,
    output logic [PC_W-1:0]                hit_pc_o,
    output logic [DEPTH-1:0]               valid_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic              valid;
        logic [SEQ_W-1:0]  seq;
        logic [ADDR_W-1:0] addr;
        logic [PC_W-1:0]   pc;
    } ld_entry_t;

    ld_entry_t ent_q [DEPTH];
    ld_entry_t ent_d [DEPTH];

    logic [DEPTH-1:0] hit, blocked, flushed;
    logic             hit_any;
    logic [IDX_W-1:0] hit_sel;
    logic             slot_ok;
    logic [IDX_W-1:0] slot_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        always_comb begin
            blocked[g] = 1'b0;
            for (int j = 0; j < SQ_DEPTH; j++) begin
                if (st_pending_i[j] &&
                    seq_is_older(32'(st_seq_i[j]), 32'(ent_q[g].seq), SEQ_W)) begin
                    blocked[g] = 1'b1;
                end
            end
        end
        assign hit[g] = ent_q[g].valid && res_i &&
                        seq_is_older(32'(res_seq_i), 32'(ent_q[g].seq), SEQ_W) &&
                        same_word(64'(res_addr_i), 64'(ent_q[g].addr));
        assign flushed[g] = flush_i &&
                            seq_is_older(32'(flush_seq_i), 32'(ent_q[g].seq), SEQ_W);
        assign valid_o[g] = ent_q[g].valid;
    end

    // Oldest matching load wins the replay report.
    always_comb begin
        hit_any = 1'b0;
        hit_sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit[i] && (!hit_any ||
                seq_is_older(32'(ent_q[i].seq), 32'(ent_q[hit_sel].seq), SEQ_W))) begin
                hit_any = 1'b1;
                hit_sel = IDX_W'(i);
            end
        end
    end

    always_comb begin
        slot_ok  = 1'b0;
        slot_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!ent_q[i].valid && !slot_ok) begin
                slot_ok  = 1'b1;
                slot_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i]       = ent_q[i];
            ent_d[i].valid = ent_q[i].valid && !flushed[i] && blocked[i] &&
                             !(hit_any && (hit_sel == IDX_W'(i)));
            if (add_i && slot_ok && (slot_idx == IDX_W'(i))) begin
                ent_d[i].valid = 1'b1;
                ent_d[i].seq   = add_seq_i;
                ent_d[i].addr  = add_addr_i;
                ent_d[i].pc    = add_pc_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign free_o   = slot_ok;
    assign hit_o    = hit_any;
    assign hit_pc_o = ent_q[hit_sel].pc;

endmodule

// File: rtl/ld_dep_wait_table.sv
module ld_dep_wait_table #(
    parameter int IDX_W        = 6,
    parameter int DECAY_CYCLES = 4096
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [IDX_W-1:0]       rd_idx_i,
    output logic                   rd_bit_o,
    input  logic                   set_i,
    input  logic [IDX_W-1:0]       set_idx_i,
    output logic [(1<<IDX_W)-1:0]  bits_o
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int CNT_W   = (DECAY_CYCLES > 1) ? $clog2(DECAY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECAY_CYCLES - 1);

    logic [ENTRIES-1:0] bits_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               wipe;

    assign wipe = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            bits_q <= '0;
        end else begin
            cnt_q <= wipe ? '0 : cnt_q + 1'b1;
            for (int i = 0; i < ENTRIES; i++) begin
                if (set_i && (set_idx_i == IDX_W'(i))) begin
                    bits_q[i] <= 1'b1;
                end else if (wipe) begin
                    bits_q[i] <= 1'b0;
                end
            end
        end
    end

    assign rd_bit_o = bits_q[rd_idx_i];
    assign bits_o   = bits_q;

endmodule

// File: rtl/ld_dep_predictor.sv
module ld_dep_predictor
    import ld_dep_pkg::*;
#(
    parameter int SQ_DEPTH     = 8,
    parameter int LQ_DEPTH     = 4,
    parameter int SEQ_W        = 6,
    parameter int ADDR_W       = 32,
    parameter int PC_W         = 32,
    parameter int WT_IDX_W     = 6,
    parameter int DECAY_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        policy_i,
    input  logic              st_alloc_i,
    input  logic [SEQ_W-1:0]  st_alloc_seq_i,
    input  logic              st_res_i,
    input  logic [SEQ_W-1:0]  st_res_seq_i,
    input  logic [ADDR_W-1:0] st_res_addr_i,
    input  logic              st_ret_i,
    input  logic [SEQ_W-1:0]  st_ret_seq_i,
    input  logic              ld_req_i,
    input  logic [PC_W-1:0]   ld_pc_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [SEQ_W-1:0]  ld_seq_i,
    input  logic              flush_i,
    input  logic [SEQ_W-1:0]  flush_seq_i,
    output logic              ld_grant_o,
    output logic              ld_stall_o,
    output logic              viol_o,
    output logic [PC_W-1:0]   viol_pc_o
);

    localparam int WT_ENTRIES = 1 << WT_IDX_W;

    dep_policy_e                     pol;
    logic [SQ_DEPTH-1:0]             st_valid;
    logic [SQ_DEPTH-1:0]             st_pending;
    logic [SQ_DEPTH-1:0][SEQ_W-1:0]  st_seq;
    logic [LQ_DEPTH-1:0]             spec_valid;
    logic                            spec_free;
    logic                            spec_hit;
    logic [PC_W-1:0]                 spec_hit_pc;
    logic [WT_ENTRIES-1:0]           wait_bits;
    logic                            wait_bit;
    logic                            older_unknown;
    logic                            must_wait;
    logic                            grant;
    logic                            viol_q;
    logic [PC_W-1:0]                 viol_pc_q;

    assign pol = dep_policy_e'(policy_i);

    ld_dep_store_table #(.DEPTH(SQ_DEPTH), .SEQ_W(SEQ_W)) u_stores (
        .clk        (clk),
        .rst        (rst),
        .alloc_i    (st_alloc_i),
        .alloc_seq_i(st_alloc_seq_i),
        .res_i      (st_res_i),
        .res_seq_i  (st_res_seq_i),
        .ret_i      (st_ret_i),
        .ret_seq_i  (st_ret_seq_i),
        .flush_i    (flush_i),
        .flush_seq_i(flush_seq_i),
        .valid_o    (st_valid),
        .pending_o  (st_pending),
        .seq_o      (st_seq)
    );

    always_comb begin
        older_unknown = 1'b0;
        for (int j = 0; j < SQ_DEPTH; j++) begin
            if (st_pending[j] && seq_is_older(32'(st_seq[j]), 32'(ld_seq_i), SEQ_W)) begin
                older_unknown = 1'b1;
            end
        end
    end

    ld_dep_wait_table #(.IDX_W(WT_IDX_W), .DECAY_CYCLES(DECAY_CYCLES)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .rd_idx_i (ld_pc_i[2 +: WT_IDX_W]),
        .rd_bit_o (wait_bit),
        .set_i    (spec_hit),
        .set_idx_i(spec_hit_pc[2 +: WT_IDX_W]),
        .bits_o   (wait_bits)
    );

    always_comb begin
        unique case (pol)
            POL_CONSERVATIVE: must_wait = 1'b1;
            POL_AGGRESSIVE:   must_wait = 1'b0;
            default:          must_wait = wait_bit;
        endcase
    end

    assign grant      = ld_req_i && (!older_unknown || (!must_wait && spec_free));
    assign ld_grant_o = grant;
    assign ld_stall_o = ld_req_i && !grant;

    ld_dep_spec_loads #(
        .DEPTH   (LQ_DEPTH),
        .SQ_DEPTH(SQ_DEPTH),
        .SEQ_W   (SEQ_W),
        .ADDR_W  (ADDR_W),
        .PC_W    (PC_W)
    ) u_spec (
        .clk         (clk),
        .rst         (rst),
        .add_i       (grant && older_unknown),
        .add_seq_i   (ld_seq_i),
        .add_addr_i  (ld_addr_i),
        .add_pc_i    (ld_pc_i),
        .st_pending_i(st_pending),
        .st_seq_i    (st_seq),
        .res_i       (st_res_i),
        .res_seq_i   (st_res_seq_i),
        .res_addr_i  (st_res_addr_i),
        .flush_i     (flush_i),
        .flush_seq_i (flush_seq_i),
        .free_o      (spec_free),
        .hit_o       (spec_hit),
        .hit_pc_o    (spec_hit_pc),
        .valid_o     (spec_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q    <= 1'b0;
            viol_pc_q <= '0;
        end else begin
            viol_q <= spec_hit;
            if (spec_hit) begin
                viol_pc_q <= spec_hit_pc;
            end
        end
    end

    assign viol_o    = viol_q;
    assign viol_pc_o = viol_pc_q;

endmodule

// File: rtl/ld_dep_predictor_chk.sv
module ld_dep_predictor_chk
    import ld_dep_pkg::*;
#(
    parameter int SQ_DEPTH = 8,
    parameter int LQ_DEPTH = 4,
    parameter int SEQ_W    = 6,
    parameter int PC_W     = 32,
    parameter int WT_IDX_W = 6
) (
    input logic                           clk,
    input logic                           rst,
    input logic [1:0]                     policy_i,
    input logic                           ld_req_i,
    input logic                           ld_grant_o,
    input logic                           ld_stall_o,
    input logic                           st_res_i,
    input logic                           viol_o,
    input logic [PC_W-1:0]                viol_pc_o,
    input logic [(1<<WT_IDX_W)-1:0]       wait_bits,
    input logic [LQ_DEPTH-1:0]            spec_valid,
    input logic                           flush_i,
    input logic [SEQ_W-1:0]               flush_seq_i,
    input logic [SQ_DEPTH-1:0]            st_valid,
    input logic [SQ_DEPTH-1:0][SEQ_W-1:0] st_seq
);

    logic             flush_d;
    logic [SEQ_W-1:0] flush_seq_d;
    logic             younger_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_d     <= 1'b0;
            flush_seq_d <= '0;
        end else begin
            flush_d     <= flush_i;
            flush_seq_d <= flush_seq_i;
        end
    end

    always_comb begin
        younger_left = 1'b0;
        for (int j = 0; j < SQ_DEPTH; j++) begin
            if (st_valid[j] && seq_is_older(32'(flush_seq_d), 32'(st_seq[j]), SEQ_W)) begin
                younger_left = 1'b1;
            end
        end
    end

    p_one_answer_r11: assert property (@(posedge clk) disable iff (rst)
        ld_req_i |-> (ld_grant_o ^ ld_stall_o));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !ld_req_i |-> !(ld_grant_o || ld_stall_o));

    p_pulse_cause_r4: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> $past(st_res_i));

    p_trained_bit_r6: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> wait_bits[viol_pc_o[2 +: WT_IDX_W]]);

    p_cons_no_track_r1: assert property (@(posedge clk) disable iff (rst)
        (policy_i == POL_CONSERVATIVE) |=>
            ($countones(spec_valid) <= $past($countones(spec_valid))));

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
        flush_d |-> !younger_left);

endmodule

bind ld_dep_predictor ld_dep_predictor_chk #(
    .SQ_DEPTH(SQ_DEPTH),
    .LQ_DEPTH(LQ_DEPTH),
    .SEQ_W   (SEQ_W),
    .PC_W    (PC_W),
    .WT_IDX_W(WT_IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .policy_i   (policy_i),
    .ld_req_i   (ld_req_i),
    .ld_grant_o (ld_grant_o),
    .ld_stall_o (ld_stall_o),
    .st_res_i   (st_res_i),
    .viol_o     (viol_o),
    .viol_pc_o  (viol_pc_o),
    .wait_bits  (wait_bits),
    .spec_valid (spec_valid),
    .flush_i    (flush_i),
    .flush_seq_i(flush_seq_i),
    .st_valid   (st_valid),
    .st_seq     (st_seq)
);

// File: tb/ld_dep_predictor_tb_top.sv
`timescale 1ns/1ps
module ld_dep_predictor_tb_top;

    localparam int SEQ_W  = 6;
    localparam int ADDR_W = 32;
    localparam int PC_W   = 32;
    localparam int DECAY  = 200;
    localparam logic [1:0] CONS = 2'd0, AGGR = 2'd1, PRED = 2'd2;

    // {policy[8:7], load seq[6:1], expected grant[0]}; stores 10 unknown, 20 known, 30 unknown
    localparam int NVEC = 10;
    localparam logic [8:0] VEC [NVEC] = '{
        {CONS, 6'd5,  1'b1}, {CONS, 6'd15, 1'b0}, {CONS, 6'd25, 1'b0},
        {CONS, 6'd8,  1'b1}, {AGGR, 6'd5,  1'b1}, {AGGR, 6'd15, 1'b1},
        {PRED, 6'd35, 1'b1}, {CONS, 6'd35, 1'b0}, {PRED, 6'd9,  1'b1},
        {CONS, 6'd11, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        policy = CONS;
    logic              st_alloc = 0, st_res = 0, st_ret = 0, ld_req = 0, flush = 0;
    logic [SEQ_W-1:0]  st_alloc_seq = '0, st_res_seq = '0, st_ret_seq = '0;
    logic [SEQ_W-1:0]  ld_seq = '0, flush_seq = '0;
    logic [ADDR_W-1:0] st_res_addr = '0, ld_addr = '0;
    logic [PC_W-1:0]   ld_pc = '0;
    logic              ld_grant, ld_stall, viol;
    logic [PC_W-1:0]   viol_pc;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    ld_dep_predictor #(.DECAY_CYCLES(DECAY)) dut_i (
        .clk(clk), .rst(rst), .policy_i(policy),
        .st_alloc_i(st_alloc), .st_alloc_seq_i(st_alloc_seq),
        .st_res_i(st_res), .st_res_seq_i(st_res_seq), .st_res_addr_i(st_res_addr),
        .st_ret_i(st_ret), .st_ret_seq_i(st_ret_seq),
        .ld_req_i(ld_req), .ld_pc_i(ld_pc), .ld_addr_i(ld_addr), .ld_seq_i(ld_seq),
        .flush_i(flush), .flush_seq_i(flush_seq),
        .ld_grant_o(ld_grant), .ld_stall_o(ld_stall),
        .viol_o(viol), .viol_pc_o(viol_pc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic alloc(input logic [SEQ_W-1:0] s);
        st_alloc = 1; st_alloc_seq = s; @(negedge clk); st_alloc = 0;
    endtask

    task automatic resolve(input logic [SEQ_W-1:0] s, input logic [ADDR_W-1:0] a);
        st_res = 1; st_res_seq = s; st_res_addr = a; @(negedge clk); st_res = 0;
    endtask

    task automatic retire(input logic [SEQ_W-1:0] s);
        st_ret = 1; st_ret_seq = s; @(negedge clk); st_ret = 0;
    endtask

    task automatic do_flush(input logic [SEQ_W-1:0] s);
        flush = 1; flush_seq = s; @(negedge clk); flush = 0;
    endtask

    task automatic load_try(input logic [1:0] pol, input logic [SEQ_W-1:0] s,
                            input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a,
                            input bit exp, input string req);
        policy = pol; ld_req = 1; ld_seq = s; ld_pc = pc; ld_addr = a;
        #1;
        chk(ld_grant == exp && ld_stall == !exp, req, "grant", 64'(ld_grant), 64'(exp));
        @(negedge clk);
        ld_req = 0;
    endtask

    task automatic viol_chk(input bit exp, input logic [PC_W-1:0] pc, input string req);
        chk(viol == exp, req, "viol", 64'(viol), 64'(exp));
        if (exp) chk(viol_pc == pc, req, "viol_pc", 64'(viol_pc), 64'(pc));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10 reset state
        #1;
        chk(!viol && !ld_grant && !ld_stall, "R10", "idle after reset",
            64'({viol, ld_grant, ld_stall}), 64'(0));
        @(negedge clk);

        // Vector table: R1 R2 R3 R8 grant decisions against a fixed store set
        alloc(6'd10); alloc(6'd20); resolve(6'd20, 32'h3000); alloc(6'd30);
        for (int v = 0; v < NVEC; v++) begin
            load_try(VEC[v][8:7], VEC[v][6:1], 32'(VEC[v][6:1]) << 2, 32'h1000,
                     VEC[v][0], "R1/R3 vector");
        end
        // R5: different word, no pulse
        resolve(6'd10, 32'h2000);
        viol_chk(1'b0, '0, "R5");
        // R4/R5: store 30 hits the younger load 35 (pc 0x8c), with a byte offset
        resolve(6'd30, 32'h1003);
        viol_chk(1'b1, 32'h8c, "R4");
        @(negedge clk);
        viol_chk(1'b0, '0, "R4 single pulse");

        // Training and oldest selection: R4 R5 R6 R3
        do_reset();
        alloc(6'd3);
        load_try(PRED, 6'd4, 32'h40, 32'h104, 1'b1, "R3");
        resolve(6'd3, 32'h106);
        viol_chk(1'b1, 32'h40, "R5 partial word");
        @(negedge clk);
        viol_chk(1'b0, '0, "R4 pulse ends");
        alloc(6'd5);
        load_try(PRED, 6'd6, 32'h40, 32'h104, 1'b0, "R3 trained stall");
        load_try(PRED, 6'd6, 32'h140, 32'h104, 1'b0, "R6 alias");
        load_try(PRED, 6'd6, 32'h44, 32'h500, 1'b1, "R6 other index");
        load_try(AGGR, 6'd9, 32'h84, 32'h300, 1'b1, "R2");
        load_try(AGGR, 6'd7, 32'h80, 32'h300, 1'b1, "R2");
        resolve(6'd5, 32'h300);
        viol_chk(1'b1, 32'h80, "R4 oldest");
        // R7 decay
        repeat (DECAY + 10) @(negedge clk);
        alloc(6'd10);
        load_try(PRED, 6'd11, 32'h40, 32'h104, 1'b1, "R7 decayed");

        // R2 capacity
        do_reset();
        alloc(6'd1);
        for (int k = 2; k <= 5; k++) begin
            load_try(AGGR, SEQ_W'(k), 32'(k) << 2, 32'h1000, 1'b1, "R2 fill");
        end
        load_try(AGGR, 6'd6, 32'h18, 32'h1000, 1'b0, "R2 full");
        resolve(6'd1, 32'h9000);
        viol_chk(1'b0, '0, "R5 no match");
        alloc(6'd8);
        load_try(AGGR, 6'd9, 32'h24, 32'h1000, 1'b1, "R2 slot freed");

        // R8 wrap
        do_reset();
        alloc(6'd62);
        load_try(CONS, 6'd1, 32'h4, 32'h0, 1'b0, "R8 wrap older");
        load_try(CONS, 6'd60, 32'h4, 32'h0, 1'b1, "R8 younger store ignored");

        // R9 flush and retire, R1 same-cycle resolve
        do_reset();
        alloc(6'd10); alloc(6'd20);
        do_flush(6'd15);
        load_try(CONS, 6'd25, 32'h8, 32'h0, 1'b0, "R9 older kept");
        resolve(6'd10, 32'h700);
        load_try(CONS, 6'd25, 32'h8, 32'h0, 1'b1, "R9 younger flushed");
        alloc(6'd30);
        load_try(CONS, 6'd35, 32'h8, 32'h0, 1'b0, "R9 before retire");
        retire(6'd30);
        load_try(CONS, 6'd35, 32'h8, 32'h0, 1'b1, "R9 retired");
        alloc(6'd40);
        st_res = 1; st_res_seq = 6'd40; st_res_addr = 32'h800;
        load_try(CONS, 6'd45, 32'h8, 32'h0, 1'b1, "R1 resolve bypass");
        st_res = 0;
        ld_req = 1; #1;
        chk(ld_grant ^ ld_stall, "R11", "exclusive", 64'({ld_grant, ld_stall}), 64'(2'b10));
        @(negedge clk); ld_req = 0;

        done = 1;
        summary();
    end

endmodule